// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Baud Generation

This block is a 16-bit timer/counter paired with a 16-bit register that serves either as a reload value or as a capture target. Four operating modes are available. In reload mode the timer counts up and refills from the register. In capture mode a trigger-pin edge stores the running count. In up/down mode the level of the trigger pin sets the count direction. In baud mode the timer produces receive and transmit bit-clock pulses for a serial port that sits outside this block. A toggling clock output can follow the timer's wrap events in any mode.

The count advances once per clock while running, or once per falling edge of a count pin. Both pins pass through a synchronizer before they are used. Software loads the count and the register through a shared write port and clears the two flags with single-cycle strobes. Mode priority, from highest to lowest, is baud, capture, up/down, reload.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the count, the register, both flags, both tick outputs and the clock output are all 0.
- R2: In reload mode an up-step from FFFFh loads the register value into the count and sets the overflow flag.
- R3: In reload mode with ext_en set, a trigger falling edge loads the register value into the count and sets the external flag. With ext_en clear the edge changes nothing.
- R4: With down_en set, a high trigger level counts up, and an up-step from FFFFh loads the register value. A low level counts down, and a down-step taken while the count equals the register value loads FFFFh. Both kinds of wrap set the overflow flag.
- R5: In up/down mode every wrap toggles the external flag, and trigger falling edges neither reload the count nor set the flag.
- R6: In capture mode with ext_en set, a trigger falling edge copies the count into the register and sets the external flag. The count wraps from FFFFh to 0000h with no reload and sets the overflow flag.
- R7: Baud mode is on while rx_sel or tx_sel is set. The timer steps every clock and reloads on wrap. Every 16th wrap gives a one-cycle pulse on rx_tick (if rx_sel is set) and on tx_tick (if tx_sel is set). The tick rate is therefore f_clk / (16 × (65536 − reload)).
- R8: In baud mode a wrap never sets the overflow flag. A trigger falling edge with ext_en set only sets the external flag.
- R9: With src_pin_sel at 0 the count steps every clock while run is high. With src_pin_sel at 1 it steps once per falling edge of cnt_pin. With run low the count holds. A pin change takes effect on the third rising clock edge after it.
- R10: While clk_out_en is set, clk_out toggles on every wrap. Otherwise clk_out holds.
- R11: cnt_wr and rld_wr load wr_data on the next edge, and a count write overrides stepping. ovf_clr and ext_clr clear their flags, but a set in the same cycle wins.
- R12: Baud mode overrides capture and up/down: with rx_sel set and cap_mode set, the count still reloads on wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| src_pin_sel | input | 1 | 1: step on cnt_pin falling edges; 0: step every clock |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | Trigger / direction pin |
| ext_en | input | 1 | Enables trigger-edge actions |
| cap_mode | input | 1 | Capture mode select |
| down_en | input | 1 | Up/down mode select |
| rx_sel | input | 1 | Timer drives the receive bit clock |
| tx_sel | input | 1 | Timer drives the transmit bit clock |
| clk_out_en | input | 1 | Enables clk_out toggling |
| wr_data | input | 16 | Write data for count or register |
| cnt_wr | input | 1 | Load the count from wr_data |
| rld_wr | input | 1 | Load the register from wr_data |
| ovf_clr | input | 1 | Clear the overflow flag |
| ext_clr | input | 1 | Clear the external flag |
| cnt_val | output | 16 | Current count |
| rld_val | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| rx_tick | output | 1 | Receive bit-clock pulse |
| tx_tick | output | 1 | Transmit bit-clock pulse |
| clk_out | output | 1 | Toggle clock output |

## Verification
An internally paced step or a register write shows on the outputs one edge later. A trigger or count-pin change needs three edges: two synchronizer stages and then the edge that acts on it. A baud pulse appears in the cycle after the 16th wrap. The bench drives every input at a falling clock edge and samples at a later falling edge. It waits exactly the number of rising edges owed: n edges for n steps, three edges after a pin edge, and a window of 320 edges from a period-2 reload for tick counting. That window must hold exactly ten pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_UPDOWN  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_BAUD    = 2'd3
    } tmr_mode_e;

    // Baud selection wins over capture, capture over up/down.
    function automatic tmr_mode_e pick_mode(input logic rx, input logic tx,
                                            input logic cap, input logic dn);
        if (rx || tx)
            return MODE_BAUD;
        else if (cap)
            return MODE_CAPTURE;
        else if (dn)
            return MODE_UPDOWN;
        return MODE_RELOAD;
    endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign level = s_q.sh[STAGES-1];
    assign fall  = s_q.prev & ~s_q.sh[STAGES-1];
endmodule

// File: rtl/tmr_baud_div.sv
module tmr_baud_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_on,
    input  logic wrap,
    input  logic rx_sel,
    input  logic tx_sel,
    output logic rx_tick,
    output logic tx_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rx;
        logic          tx;
    } div_t;

    div_t s_d, s_q;
    logic fire;

    always_comb begin
        s_d  = s_q;
        fire = baud_on && wrap && (s_q.cnt == LAST);
        if (!baud_on)
            s_d.cnt = '0;
        else if (wrap)
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        s_d.rx = fire && rx_sel;
        s_d.tx = fire && tx_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign rx_tick = s_q.rx;
    assign tx_tick = s_q.tx;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  tmr_mode_e    mode,
    input  logic         trig_lvl,
    input  logic         trig_fall,
    input  logic         ext_en,
    input  logic         clk_out_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_wr,
    input  logic         rld_wr,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] rld,
    output logic         ovf,
    output logic         ext,
    output logic         clko,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         ovf;
        logic         ext;
        logic         clko;
    } core_t;

    core_t s_d, s_q;
    logic  go_down, up_hit, dn_hit, ext_hit, cap_now;

    always_comb begin
        s_d     = s_q;
        wrap    = 1'b0;
        go_down = (mode == MODE_UPDOWN) && !trig_lvl;
        up_hit  = (s_q.cnt == TOP);
        dn_hit  = (s_q.cnt == s_q.rld);
        ext_hit = trig_fall && ext_en;
        cap_now = ext_hit && (mode == MODE_CAPTURE);

        if (step) begin
            if (go_down) begin
                wrap      = dn_hit;
                s_d.cnt   = dn_hit ? TOP : s_q.cnt - 1'b1;
            end else begin
                wrap      = up_hit;
                if (!up_hit)
                    s_d.cnt = s_q.cnt + 1'b1;
                else if (mode == MODE_CAPTURE)
                    s_d.cnt = '0;
                else
                    s_d.cnt = s_q.rld;
            end
        end

        s_d.ovf = ovf_clr ? 1'b0 : s_q.ovf;
        s_d.ext = ext_clr ? 1'b0 : s_q.ext;

        if (ext_hit) begin
            case (mode)
                MODE_RELOAD: begin
                    s_d.cnt = s_q.rld;
                    s_d.ext = 1'b1;
                end
                MODE_CAPTURE: begin
                    s_d.rld = s_q.cnt;
                    s_d.ext = 1'b1;
                end
                MODE_BAUD:   s_d.ext = 1'b1;
                default:     ;
            endcase
        end

        if (cnt_wr) begin
            s_d.cnt = wr_data;
            wrap    = 1'b0;
        end

        if (wrap) begin
            if (mode != MODE_BAUD)
                s_d.ovf = 1'b1;
            if (mode == MODE_UPDOWN)
                s_d.ext = ~s_d.ext;
            if (clk_out_en)
                s_d.clko = ~s_q.clko;
        end

        if (rld_wr && !cap_now)
            s_d.rld = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign rld  = s_q.rld;
    assign ovf  = s_q.ovf;
    assign ext  = s_q.ext;
    assign clko = s_q.clko;
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import tmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int BAUD_DIV    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         src_pin_sel,
    input  logic         cnt_pin,
    input  logic         trig_pin,
    input  logic         ext_en,
    input  logic         cap_mode,
    input  logic         down_en,
    input  logic         rx_sel,
    input  logic         tx_sel,
    input  logic         clk_out_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_wr,
    input  logic         rld_wr,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] cnt_val,
    output logic [W-1:0] rld_val,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         rx_tick,
    output logic         tx_tick,
    output logic         clk_out
);
    tmr_mode_e mode;
    logic      trig_lvl_w, trig_fall_w, cpin_lvl_w, cpin_fall_w;
    logic      step_w, wrap_w, baud_on;

    assign mode    = pick_mode(rx_sel, tx_sel, cap_mode, down_en);
    assign baud_on = (mode == MODE_BAUD);
    assign step_w  = run && (baud_on || !src_pin_sel || cpin_fall_w);

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_pin),
        .level (trig_lvl_w),
        .fall  (trig_fall_w)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cnt_pin),
        .level (cpin_lvl_w),
        .fall  (cpin_fall_w)
    );

    tmr_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_w),
        .mode       (mode),
        .trig_lvl   (trig_lvl_w),
        .trig_fall  (trig_fall_w),
        .ext_en     (ext_en),
        .clk_out_en (clk_out_en),
        .wr_data    (wr_data),
        .cnt_wr     (cnt_wr),
        .rld_wr     (rld_wr),
        .ovf_clr    (ovf_clr),
        .ext_clr    (ext_clr),
        .cnt        (cnt_val),
        .rld        (rld_val),
        .ovf        (ovf_flag),
        .ext        (ext_flag),
        .clko       (clk_out),
        .wrap       (wrap_w)
    );

    tmr_baud_div #(.DIV(BAUD_DIV)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud_on (baud_on),
        .wrap    (wrap_w),
        .rx_sel  (rx_sel),
        .tx_sel  (tx_sel),
        .rx_tick (rx_tick),
        .tx_tick (tx_tick)
    );

    // The count pin's settled level is not needed beyond its edge.
    logic unused_lvl;
    assign unused_lvl = cpin_lvl_w;
endmodule

// File: rtl/updn_reload_timer_chk.sv
module updn_reload_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         src_pin_sel,
    input logic         ext_en,
    input logic         cap_mode,
    input logic         down_en,
    input logic         rx_sel,
    input logic         tx_sel,
    input logic         clk_out_en,
    input logic         cnt_wr,
    input logic         rld_wr,
    input logic [W-1:0] cnt_val,
    input logic [W-1:0] rld_val,
    input logic         ovf_flag,
    input logic         ext_flag,
    input logic         rx_tick,
    input logic         tx_tick,
    input logic         clk_out,
    input logic         trig_fall
);
    // R2
    reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_pin_sel && !rx_sel && !tx_sel && !cap_mode && !down_en &&
         !cnt_wr && !rld_wr && (cnt_val == '1))
        |=> (cnt_val == $past(rld_val)) && ovf_flag);

    // R6
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !rx_sel && !tx_sel && ext_en && trig_fall)
        |=> (rld_val == $past(cnt_val)) && ext_flag);

    // R8
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_sel || tx_sel) && !ovf_flag) |=> !ovf_flag);

    // R7
    rx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> $past(rx_sel));

    // R7
    tx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> $past(tx_sel));

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |=> !rx_tick);

    // R10
    clkout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> $past(clk_out_en));

    // R9
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !(ext_en && trig_fall)) |=> $stable(cnt_val));
endmodule

bind updn_reload_timer updn_reload_timer_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .src_pin_sel (src_pin_sel),
    .ext_en      (ext_en),
    .cap_mode    (cap_mode),
    .down_en     (down_en),
    .rx_sel      (rx_sel),
    .tx_sel      (tx_sel),
    .clk_out_en  (clk_out_en),
    .cnt_wr      (cnt_wr),
    .rld_wr      (rld_wr),
    .cnt_val     (cnt_val),
    .rld_val     (rld_val),
    .ovf_flag    (ovf_flag),
    .ext_flag    (ext_flag),
    .rx_tick     (rx_tick),
    .tx_tick     (tx_tick),
    .clk_out     (clk_out),
    .trig_fall   (trig_fall_w)
);

// File: tb/tb_updn_reload_timer.sv
module tb_updn_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 0, src_pin_sel = 0, cnt_pin = 1, trig_pin = 1;
    logic        ext_en = 0, cap_mode = 0, down_en = 0, rx_sel = 0, tx_sel = 0;
    logic        clk_out_en = 0, cnt_wr = 0, rld_wr = 0, ovf_clr = 0, ext_clr = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_val, rld_val;
    logic        ovf_flag, ext_flag, rx_tick, tx_tick, clk_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .src_pin_sel(src_pin_sel),
        .cnt_pin(cnt_pin), .trig_pin(trig_pin), .ext_en(ext_en),
        .cap_mode(cap_mode), .down_en(down_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
        .clk_out_en(clk_out_en), .wr_data(wr_data), .cnt_wr(cnt_wr),
        .rld_wr(rld_wr), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
        .cnt_val(cnt_val), .rld_val(rld_val), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .rx_tick(rx_tick), .tx_tick(tx_tick), .clk_out(clk_out)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        cap;
        logic        dn;
        logic        trig;
        logic [15:0] rld;
        logic [15:0] start;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
        logic        exp_ext;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd2, 1'b0, 1'b0, 1'b1, 16'h1234, 16'hFFFD, 8'd2, 16'hFFFF, 1'b0, 1'b0}, // R2 before wrap
        '{8'd2, 1'b0, 1'b0, 1'b1, 16'h1234, 16'hFFFD, 8'd3, 16'h1234, 1'b1, 1'b0}, // R2 wrap
        '{8'd2, 1'b0, 1'b0, 1'b1, 16'h1234, 16'hFFFD, 8'd5, 16'h1236, 1'b1, 1'b0}, // R2 after wrap
        '{8'd4, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0012, 8'd2, 16'h0010, 1'b0, 1'b0}, // R4 down to reload
        '{8'd4, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0012, 8'd3, 16'hFFFF, 1'b1, 1'b1}, // R4 R5 underflow
        '{8'd4, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0012, 8'd4, 16'hFFFE, 1'b1, 1'b1}, // R4 keeps down
        '{8'd4, 1'b0, 1'b1, 1'b1, 16'h0100, 16'hFFFE, 8'd3, 16'h0101, 1'b1, 1'b1}, // R4 R5 up wrap
        '{8'd5, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1, 1'b0}, // R5 two toggles
        '{8'd2, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 8'd1, 16'hFFFF, 1'b1, 1'b0}, // R2 reload FFFF
        '{8'd6, 1'b1, 1'b0, 1'b1, 16'h5555, 16'hFFFF, 8'd2, 16'h0001, 1'b1, 1'b0}  // R6 free wrap
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] c, input logic [15:0] r);
        @(negedge clk); wr_data = c; cnt_wr = 1; ovf_clr = 1; ext_clr = 1;
        @(negedge clk); cnt_wr = 0; wr_data = r; rld_wr = 1;
        @(negedge clk); rld_wr = 0; ovf_clr = 0; ext_clr = 0;
    endtask

    task automatic trig_drop;
        @(negedge clk); trig_pin = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic trig_restore;
        trig_pin = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_ticks(input int cyc, output int nrx, output int ntx);
        nrx = 0; ntx = 0;
        run = 1;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rx_tick) nrx++;
            if (tx_tick) ntx++;
        end
        run = 0;
    endtask

    initial begin
        int nrx, ntx;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cnt", cnt_val, 16'h0);
        check("R1 rld", rld_val, 16'h0);
        check("R1 flags/ticks/clkout", {11'd0, ovf_flag, ext_flag, rx_tick, tx_tick, clk_out}, 16'h0);

        // Table walk: R2 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            cap_mode = VECS[v].cap; down_en = VECS[v].dn; trig_pin = VECS[v].trig;
            load(VECS[v].start, VECS[v].rld);
            repeat (3) @(negedge clk);
            run = 1;
            repeat (int'(VECS[v].n)) @(negedge clk);
            run = 0;
            check($sformatf("R%0d vec%0d cnt", VECS[v].req, v), cnt_val, VECS[v].exp_cnt);
            check($sformatf("R%0d vec%0d ovf/ext", VECS[v].req, v),
                  {14'd0, ovf_flag, ext_flag}, {14'd0, VECS[v].exp_ovf, VECS[v].exp_ext});
        end
        cap_mode = 0; down_en = 0; trig_pin = 1;
        repeat (3) @(negedge clk);

        // R3 trigger reload
        ext_en = 1;
        load(16'h0007, 16'h4000);
        trig_drop();
        check("R3 edge reload cnt", cnt_val, 16'h4000);
        check("R3 edge flags", {14'd0, ovf_flag, ext_flag}, 16'h0001);
        trig_restore();
        // R3 ignored without ext_en
        ext_en = 0;
        load(16'h0007, 16'h4000);
        trig_drop();
        check("R3 no-enable cnt", cnt_val, 16'h0007);
        check("R3 no-enable ext", {15'd0, ext_flag}, 16'h0);
        trig_restore();

        // R6 capture
        ext_en = 1; cap_mode = 1;
        load(16'hABCD, 16'h0000);
        trig_drop();
        check("R6 captured rld", rld_val, 16'hABCD);
        check("R6 ext set", {15'd0, ext_flag}, 16'h1);
        trig_restore();
        cap_mode = 0;

        // R5 up/down ignores edges
        down_en = 1;
        load(16'h0007, 16'h4000);
        trig_drop();
        check("R5 no reload", cnt_val, 16'h0007);
        check("R5 no ext", {15'd0, ext_flag}, 16'h0);
        trig_restore();
        down_en = 0; ext_en = 0;

        // R7 R8 R12 baud with rx only, capture also set
        cap_mode = 1; rx_sel = 1;
        load(16'hFFFE, 16'hFFFE);
        count_ticks(320, nrx, ntx);
        check("R7 rx ticks", 16'(nrx), 16'd10);
        check("R7 tx idle", 16'(ntx), 16'd0);
        check("R8 no ovf", {15'd0, ovf_flag}, 16'h0);
        check("R12 baud reloads", cnt_val, 16'hFFFE);
        // R7 both directions
        tx_sel = 1;
        load(16'hFFFE, 16'hFFFE);
        count_ticks(320, nrx, ntx);
        check("R7 both rx", 16'(nrx), 16'd10);
        check("R7 both tx", 16'(ntx), 16'd10);
        // R8 edge in baud only sets flag
        ext_en = 1;
        load(16'h0003, 16'hFFFE);
        trig_drop();
        check("R8 edge ext", {15'd0, ext_flag}, 16'h1);
        check("R8 edge no reload", cnt_val, 16'h0003);
        trig_restore();
        rx_sel = 0; tx_sel = 0; cap_mode = 0; ext_en = 0;

        // R10 clock out
        clk_out_en = 1;
        load(16'hFFFE, 16'hFFFE);
        run = 1;
        repeat (2) @(negedge clk);
        check("R10 toggle 1", {15'd0, clk_out}, 16'h1);
        repeat (2) @(negedge clk);
        run = 0;
        check("R10 toggle 2", {15'd0, clk_out}, 16'h0);
        clk_out_en = 0;
        // R11 flag clear
        check("R11 ovf before clear", {15'd0, ovf_flag}, 16'h1);
        ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        check("R11 ovf cleared", {15'd0, ovf_flag}, 16'h0);

        // R9 pin-driven counting and hold
        src_pin_sel = 1;
        load(16'h0100, 16'h0000);
        run = 1;
        for (int p = 0; p < 5; p++) begin
            cnt_pin = 0; repeat (4) @(negedge clk);
            cnt_pin = 1; repeat (4) @(negedge clk);
        end
        check("R9 pin edges counted", cnt_val, 16'h0105);
        run = 0; src_pin_sel = 0;
        repeat (10) @(negedge clk);
        check("R9 hold while stopped", cnt_val, 16'h0105);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule